// File: doc/BRIEF.md
# Supervisor CSR File with Trap Entry and Return

This block holds the nine supervisor control and status registers of a small core. Each register sits at a fixed local address. The pipeline reaches the registers through one access port that offers three operations: write, set bits and clear bits. Every access returns the value the register held before the access, in the same cycle.

The same register file takes trap events. A trap entry stores the faulting PC, the cause and a fault value. It then sends the fetch unit to the trap vector and moves the hart to supervisor mode. A trap return sends fetch to the saved PC, drops the hart to user mode and asks for a flush of the translation buffers.

An access is illegal in any of these cases: it is made in user mode, it uses an address that is not in the map, or it uses the reserved operation code. An illegal access changes nothing and reads as zero.

Top module: `sup_csr_file`

## Requirements
- R1: After reset, the hart is in supervisor mode (`privSuper`=1). Every register reads 0, except the status register, which reads its fixed value (default 0x00000200). `redirectValid` and `tlbFlush` are 0.
- R2: The register map is: status 0x100, trap vector 0x101, trap PC 0x102, trap cause 0x103, trap value 0x104, translation control 0x105, mix seed 0x120, protection lock 0x130, capability mask 0x140. Any other address raises `csrIllegal`, writes nothing and returns `csrRdata`=0.
- R3: With `csrOp`=2'b01 (write), a legal access stores `csrWdata`. `csrRdata` shows the previous contents during the access cycle.
- R4: With `csrOp`=2'b10 (set), a legal access ORs `csrWdata` into the register. With `csrOp`=2'b11 (clear), it clears the bits that are 1 in `csrWdata`. Either operation writes nothing when `csrSrcZero`=1.
- R5: Only bits 1:0 of the status register (mask 0x00000003) take writes. Its other bits always read their fixed value.
- R6: The trap vector and trap PC registers always hold values with bits 1:0 equal to zero. This holds for CSR writes and for trap capture.
- R7: Any access in user mode raises `csrIllegal` and changes no register. The reserved code `csrOp`=2'b00 is illegal in every mode.
- R8: A trap entry (`trapValid`=1) does three things. It asserts `redirectValid` with `redirectPc` equal to the trap vector. On the next edge it stores `trapPc` (aligned), `trapCause` (all 32 bits, so an interrupt code such as 0x8000000b keeps its top bit) and `trapValue`. It sets supervisor mode.
- R9: A trap entry takes priority over a trap return and over a CSR write in the same cycle; the CSR write is dropped.
- R10: A trap return (`retValid`=1 without a trap) asserts `redirectValid` with `redirectPc` equal to the trap PC register. It raises `tlbFlush` for that cycle. From the next cycle the hart is in user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csrValid | input | 1 | CSR access present this cycle |
| csrOp | input | 2 | 01 write, 10 set, 11 clear, 00 reserved |
| csrAddr | input | 12 | CSR address |
| csrWdata | input | 32 | Write, set or clear operand |
| csrSrcZero | input | 1 | Source register is x0; suppresses set and clear writes |
| csrRdata | output | 32 | Previous value of the addressed register; 0 when illegal |
| csrIllegal | output | 1 | Illegal-instruction condition for this access |
| trapValid | input | 1 | Trap entry request |
| trapPc | input | 32 | PC of the trapping instruction |
| trapCause | input | 32 | Cause code |
| trapValue | input | 32 | Fault address or instruction word |
| retValid | input | 1 | Trap return request |
| redirectValid | output | 1 | Fetch must jump to `redirectPc` |
| redirectPc | output | 32 | Trap vector on entry, saved trap PC on return |
| tlbFlush | output | 1 | Flush translation buffers (trap return) |
| privSuper | output | 1 | 1 = supervisor mode, 0 = user mode |

## Verification
The assertions assume that all inputs are settled away from the clock edge. They also assume that `csrOp` is meaningful only while `csrValid` is high. They do not rely on trap entry and trap return being mutually exclusive; they encode the priority instead.

The stimulus changes inputs only at falling edges and holds the access port idle outside each access. It raises trap and return requests one at a time, except for one deliberate collision between a trap and a CSR write. That collision exercises the priority rule.

// File: rtl/scsr_pkg.sv
package scsr_pkg;

  localparam int XLEN    = 32;
  localparam int ADDR_W  = 12;
  localparam int NUM_CSR = 9;

  localparam int IDX_STATUS = 0;
  localparam int IDX_TVEC   = 1;
  localparam int IDX_EPC    = 2;
  localparam int IDX_CAUSE  = 3;
  localparam int IDX_TVAL   = 4;
  localparam int IDX_XLAT   = 5;
  localparam int IDX_SEED   = 6;
  localparam int IDX_LOCK   = 7;
  localparam int IDX_CAPS   = 8;

  localparam logic [XLEN-1:0] STATUS_WMASK = 32'h0000_0003;
  localparam logic [XLEN-1:0] ALIGN_WMASK  = 32'hFFFF_FFFC;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csrOp_e;

  typedef struct packed {
    logic               csrWr;
    logic [NUM_CSR-1:0] sel;
    csrOp_e             op;
    logic               trapTake;
    logic               retTake;
  } ctrlStrobes_t;

  function automatic logic [ADDR_W-1:0] csrAddrOf(input int idx);
    case (idx)
      IDX_STATUS: return 12'h100;
      IDX_TVEC:   return 12'h101;
      IDX_EPC:    return 12'h102;
      IDX_CAUSE:  return 12'h103;
      IDX_TVAL:   return 12'h104;
      IDX_XLAT:   return 12'h105;
      IDX_SEED:   return 12'h120;
      IDX_LOCK:   return 12'h130;
      default:    return 12'h140;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] csrMaskOf(input int idx);
    case (idx)
      IDX_STATUS:       return STATUS_WMASK;
      IDX_TVEC, IDX_EPC: return ALIGN_WMASK;
      default:          return '1;
    endcase
  endfunction

  function automatic bit csrCaptures(input int idx);
    return (idx == IDX_EPC) || (idx == IDX_CAUSE) || (idx == IDX_TVAL);
  endfunction

endpackage

// File: rtl/scsr_reg_cell.sv
module scsr_reg_cell
  import scsr_pkg::*;
#(
  parameter logic [XLEN-1:0] WMASK   = '1,
  parameter logic [XLEN-1:0] RESETV  = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  csrOp_e          op,
  input  logic [XLEN-1:0] wdata,
  input  logic            capEn,
  input  logic [XLEN-1:0] capData,
  output logic [XLEN-1:0] q
);

  logic [XLEN-1:0] modVal;
  logic [XLEN-1:0] nextVal;

  always_comb begin
    case (op)
      OP_WRITE: modVal = wdata;
      OP_SET:   modVal = q | wdata;
      OP_CLEAR: modVal = q & ~wdata;
      default:  modVal = q;
    endcase
    nextVal = (q & ~WMASK) | (modVal & WMASK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      q <= RESETV;
    else if (capEn) q <= capData & WMASK;
    else if (wrEn)  q <= nextVal;
  end

endmodule

// File: rtl/scsr_ctrl.sv
module scsr_ctrl
  import scsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csrValid,
  input  logic [1:0]        csrOp,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              csrSrcZero,
  input  logic              trapValid,
  input  logic              retValid,
  output ctrlStrobes_t      strobes,
  output logic              csrIllegal,
  output logic              redirectValid,
  output logic              tlbFlush,
  output logic              privSuper
);

  logic [NUM_CSR-1:0] hit;
  logic               addrKnown;
  logic               legalAcc;
  logic               wantsWrite;
  csrOp_e             opDec;

  for (genvar i = 0; i < NUM_CSR; i++) begin : g_dec
    assign hit[i] = (csrAddr == csrAddrOf(i));
  end

  assign opDec      = csrOp_e'(csrOp);
  assign addrKnown  = |hit;
  assign csrIllegal = csrValid && (!privSuper || !addrKnown || opDec == OP_NONE);
  assign legalAcc   = csrValid && !csrIllegal;
  assign wantsWrite = (opDec == OP_WRITE) || !csrSrcZero;

  always_comb begin
    strobes.sel      = hit & {NUM_CSR{legalAcc}};
    strobes.op       = opDec;
    strobes.trapTake = trapValid;
    strobes.retTake  = retValid && !trapValid;
    strobes.csrWr    = legalAcc && wantsWrite && !trapValid && !retValid;
  end

  assign redirectValid = trapValid || retValid;
  assign tlbFlush      = strobes.retTake;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 privSuper <= 1'b1;
    else if (strobes.trapTake) privSuper <= 1'b1;
    else if (strobes.retTake)  privSuper <= 1'b0;
  end

endmodule

// File: rtl/scsr_datapath.sv
module scsr_datapath
  import scsr_pkg::*;
#(
  parameter logic [XLEN-1:0] FIXED_STATUS = 32'h0000_0200
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobes_t    strobes,
  input  logic [XLEN-1:0] csrWdata,
  input  logic [XLEN-1:0] trapPc,
  input  logic [XLEN-1:0] trapCause,
  input  logic [XLEN-1:0] trapValue,
  output logic [XLEN-1:0] csrRdata,
  output logic [XLEN-1:0] redirectPc
);

  logic [XLEN-1:0] csrQ    [NUM_CSR];
  logic [XLEN-1:0] capSrc  [NUM_CSR];

  always_comb begin
    for (int i = 0; i < NUM_CSR; i++) capSrc[i] = '0;
    capSrc[IDX_EPC]   = trapPc;
    capSrc[IDX_CAUSE] = trapCause;
    capSrc[IDX_TVAL]  = trapValue;
  end

  for (genvar i = 0; i < NUM_CSR; i++) begin : g_csr
    localparam logic [XLEN-1:0] MASK_I  = csrMaskOf(i);
    localparam logic [XLEN-1:0] RESET_I = (i == IDX_STATUS) ? (FIXED_STATUS & ~MASK_I) : '0;
    localparam bit              CAP_I   = csrCaptures(i);

    scsr_reg_cell #(
      .WMASK  (MASK_I),
      .RESETV (RESET_I)
    ) cell_i (
      .clk     (clk),
      .rstN    (rstN),
      .wrEn    (strobes.csrWr && strobes.sel[i]),
      .op      (strobes.op),
      .wdata   (csrWdata),
      .capEn   (strobes.trapTake && CAP_I),
      .capData (capSrc[i]),
      .q       (csrQ[i])
    );
  end

  always_comb begin
    csrRdata = '0;
    for (int i = 0; i < NUM_CSR; i++) begin
      if (strobes.sel[i]) csrRdata = csrRdata | csrQ[i];
    end
  end

  assign redirectPc = strobes.retTake ? csrQ[IDX_EPC] : csrQ[IDX_TVEC];

endmodule

// File: rtl/sup_csr_file.sv
module sup_csr_file
  import scsr_pkg::*;
#(
  parameter logic [31:0] FIXED_STATUS = 32'h0000_0200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csrValid,
  input  logic [1:0]  csrOp,
  input  logic [11:0] csrAddr,
  input  logic [31:0] csrWdata,
  input  logic        csrSrcZero,
  output logic [31:0] csrRdata,
  output logic        csrIllegal,
  input  logic        trapValid,
  input  logic [31:0] trapPc,
  input  logic [31:0] trapCause,
  input  logic [31:0] trapValue,
  input  logic        retValid,
  output logic        redirectValid,
  output logic [31:0] redirectPc,
  output logic        tlbFlush,
  output logic        privSuper
);

  ctrlStrobes_t strobes;

  scsr_ctrl ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .csrValid      (csrValid),
    .csrOp         (csrOp),
    .csrAddr       (csrAddr),
    .csrSrcZero    (csrSrcZero),
    .trapValid     (trapValid),
    .retValid      (retValid),
    .strobes       (strobes),
    .csrIllegal    (csrIllegal),
    .redirectValid (redirectValid),
    .tlbFlush      (tlbFlush),
    .privSuper     (privSuper)
  );

  scsr_datapath #(
    .FIXED_STATUS (FIXED_STATUS)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .csrWdata   (csrWdata),
    .trapPc     (trapPc),
    .trapCause  (trapCause),
    .trapValue  (trapValue),
    .csrRdata   (csrRdata),
    .redirectPc (redirectPc)
  );

endmodule

// File: rtl/sup_csr_file_chk.sv
module sup_csr_file_chk #(
  parameter logic [31:0] FIXED_STATUS = 32'h0000_0200
) (
  input logic        clk,
  input logic        rstN,
  input logic        csrValid,
  input logic [1:0]  csrOp,
  input logic [11:0] csrAddr,
  input logic [31:0] csrWdata,
  input logic        csrSrcZero,
  input logic [31:0] csrRdata,
  input logic        csrIllegal,
  input logic        trapValid,
  input logic [31:0] trapPc,
  input logic [31:0] trapCause,
  input logic [31:0] trapValue,
  input logic        retValid,
  input logic        redirectValid,
  input logic [31:0] redirectPc,
  input logic        tlbFlush,
  input logic        privSuper
);

  logic mapped;
  assign mapped = csrAddr inside {12'h100, 12'h101, 12'h102, 12'h103, 12'h104,
                                  12'h105, 12'h120, 12'h130, 12'h140};

  p_unmapped_illegal_r2: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && !mapped) |-> csrIllegal);

  p_illegal_reads_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    csrIllegal |-> (csrRdata == 32'h0));

  p_status_fixed_r5: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && !csrIllegal && csrAddr == 12'h100)
      |-> ((csrRdata & 32'hFFFF_FFFC) == (FIXED_STATUS & 32'hFFFF_FFFC)));

  p_aligned_target_r6: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> (redirectPc[1:0] == 2'b00));

  p_user_illegal_r7: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && !privSuper) |-> csrIllegal);

  p_trap_super_r8: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> privSuper);

  p_trap_no_flush_r9: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |-> (redirectValid && !tlbFlush));

  p_ret_flush_r10: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && !trapValid) |-> (redirectValid && tlbFlush));

  p_ret_user_r10: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && !trapValid) |=> !privSuper);

  p_mode_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!trapValid && !retValid) |=> $stable(privSuper));

endmodule

bind sup_csr_file sup_csr_file_chk #(.FIXED_STATUS(FIXED_STATUS)) chk_i (.*);

// File: tb/sup_csr_file_tb_top.sv
module sup_csr_file_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrValid = 1'b0;
  logic [1:0]  csrOp = 2'b00;
  logic [11:0] csrAddr = '0;
  logic [31:0] csrWdata = '0;
  logic        csrSrcZero = 1'b0;
  logic [31:0] csrRdata;
  logic        csrIllegal;
  logic        trapValid = 1'b0;
  logic [31:0] trapPc = '0;
  logic [31:0] trapCause = '0;
  logic [31:0] trapValue = '0;
  logic        retValid = 1'b0;
  logic        redirectValid;
  logic [31:0] redirectPc;
  logic        tlbFlush;
  logic        privSuper;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  sup_csr_file dut_i (.*);

  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] addr;
    logic [31:0] wd;
    logic        sz;
    logic [31:0] rd;
    logic        ill;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 12'h101, 32'h1234_5677, 1'b0, 32'h0000_0000, 1'b0},
    '{2'd2, 12'h101, 32'h0000_0000, 1'b1, 32'h1234_5674, 1'b0},
    '{2'd1, 12'h100, 32'hFFFF_FFFF, 1'b0, 32'h0000_0200, 1'b0},
    '{2'd3, 12'h100, 32'h0000_0001, 1'b0, 32'h0000_0203, 1'b0},
    '{2'd2, 12'h100, 32'h0000_0000, 1'b1, 32'h0000_0202, 1'b0},
    '{2'd1, 12'h120, 32'hA5A5_A5A5, 1'b0, 32'h0000_0000, 1'b0},
    '{2'd2, 12'h120, 32'h0F0F_0000, 1'b0, 32'hA5A5_A5A5, 1'b0},
    '{2'd3, 12'h120, 32'h0000_00A5, 1'b0, 32'hAFAF_A5A5, 1'b0},
    '{2'd3, 12'h120, 32'hFFFF_FFFF, 1'b1, 32'hAFAF_A500, 1'b0},
    '{2'd1, 12'h120, 32'h0000_0000, 1'b0, 32'hAFAF_A500, 1'b0},
    '{2'd1, 12'h121, 32'h0000_0001, 1'b0, 32'h0000_0000, 1'b1},
    '{2'd2, 12'h140, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b0},
    '{2'd1, 12'h102, 32'h0000_0FFF, 1'b0, 32'h0000_0000, 1'b0},
    '{2'd2, 12'h102, 32'h0000_0000, 1'b1, 32'h0000_0FFC, 1'b0},
    '{2'd0, 12'h105, 32'h1111_1111, 1'b0, 32'h0000_0000, 1'b1},
    '{2'd1, 12'h105, 32'h8000_0001, 1'b0, 32'h0000_0000, 1'b0},
    '{2'd2, 12'h105, 32'h0000_0000, 1'b1, 32'h8000_0001, 1'b0},
    '{2'd1, 12'h130, 32'h0000_0007, 1'b0, 32'h0000_0000, 1'b0},
    '{2'd2, 12'h130, 32'h0000_0000, 1'b1, 32'h0000_0007, 1'b0},
    '{2'd1, 12'h103, 32'h0000_0011, 1'b0, 32'h0000_0000, 1'b0},
    '{2'd1, 12'h104, 32'h0000_0022, 1'b0, 32'h0000_0000, 1'b0},
    '{2'd2, 12'h103, 32'h0000_0000, 1'b1, 32'h0000_0011, 1'b0},
    '{2'd2, 12'h104, 32'h0000_0000, 1'b1, 32'h0000_0022, 1'b0},
    '{2'd2, 12'h120, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FIAL_MARK %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] op, input logic [11:0] addr,
                        input logic [31:0] wd, input logic sz);
    csrValid = 1'b1; csrOp = op; csrAddr = addr; csrWdata = wd; csrSrcZero = sz;
  endtask

  task automatic idle();
    csrValid = 1'b0; csrOp = 2'b00; csrWdata = '0; csrSrcZero = 1'b0;
    trapValid = 1'b0; retValid = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic readCsr(input string req, input logic [11:0] addr, input logic [31:0] exp);
    access(2'd2, addr, 32'h0, 1'b1);
    #1;
    chk(req, csrRdata, exp);
    tick();
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    chk("R1 privSuper", {31'h0, privSuper}, 32'h1);
    chk("R1 redirectValid", {31'h0, redirectValid}, 32'h0);
    chk("R1 tlbFlush", {31'h0, tlbFlush}, 32'h0);
    readCsr("R1 status reset", 12'h100, 32'h0000_0200);
    readCsr("R1 tvec reset", 12'h101, 32'h0);

    // R2 R3 R4 R5 R6 R7: table walk
    for (int i = 0; i < NV; i++) begin
      access(VECS[i].op, VECS[i].addr, VECS[i].wd, VECS[i].sz);
      #1;
      chk($sformatf("R2/R3/R4/R5/R6 vec%0d rdata", i), csrRdata, VECS[i].rd);
      chk($sformatf("R2/R7 vec%0d illegal", i), {31'h0, csrIllegal}, {31'h0, VECS[i].ill});
      tick();
    end

    // R10: trap return to saved PC 0xFFC
    retValid = 1'b1;
    #1;
    chk("R10 redirectValid", {31'h0, redirectValid}, 32'h1);
    chk("R10 redirectPc", redirectPc, 32'h0000_0FFC);
    chk("R10 tlbFlush", {31'h0, tlbFlush}, 32'h1);
    tick();
    chk("R10 user mode", {31'h0, privSuper}, 32'h0);
    chk("R10 flush ends", {31'h0, tlbFlush}, 32'h0);

    // R7: user access illegal, no write
    access(2'd1, 12'h120, 32'h0000_0005, 1'b0);
    #1;
    chk("R7 user illegal", {31'h0, csrIllegal}, 32'h1);
    chk("R7 user rdata", csrRdata, 32'h0);
    tick();

    // R8: interrupt trap from user mode
    trapValid = 1'b1; trapPc = 32'h0000_1003; trapCause = 32'h8000_000B; trapValue = 32'h0000_DEAD;
    #1;
    chk("R8 redirectValid", {31'h0, redirectValid}, 32'h1);
    chk("R8 redirectPc", redirectPc, 32'h1234_5674);
    chk("R8 no flush", {31'h0, tlbFlush}, 32'h0);
    tick();
    chk("R8 super mode", {31'h0, privSuper}, 32'h1);
    readCsr("R7 seed untouched", 12'h120, 32'h0);
    readCsr("R8 R6 epc", 12'h102, 32'h0000_1000);
    readCsr("R8 cause", 12'h103, 32'h8000_000B);
    readCsr("R8 tval", 12'h104, 32'h0000_DEAD);

    // R9: trap with same-cycle CSR write and return
    access(2'd1, 12'h104, 32'h0000_9999, 1'b0);
    trapValid = 1'b1; retValid = 1'b1;
    trapPc = 32'h0000_2000; trapCause = 32'h2; trapValue = 32'h77;
    #1;
    chk("R9 redirect to vector", redirectPc, 32'h1234_5674);
    chk("R9 no flush", {31'h0, tlbFlush}, 32'h0);
    tick();
    chk("R9 still super", {31'h0, privSuper}, 32'h1);
    readCsr("R9 tval from trap", 12'h104, 32'h0000_0077);
    readCsr("R9 cause", 12'h103, 32'h0000_0002);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: R1 run did not complete actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule